// File: doc/BRIEF.md
# Router Power-Gating Handshake Controller

Each router of a two-dimensional mesh has one of these controllers. It decides when the router core may lose power and when it has to come back. The only trigger is the power state of the processor core attached to the router. Network traffic is never used to make the decision. Before the router turns off, the controller asks every existing neighbour for permission with a two-bit request/response protocol. It then lets in-flight traffic drain, enters sleep, and relays traffic in bypass mode while gated. When the core wakes, the controller runs a timed wakeup phase before the router is usable again.

The controller follows a restricted policy: no two gated routers may be next to each other in a row or column. It keeps a register per neighbour holding that neighbour's last advertised power state. It declines to start a power-down while any neighbour is not Active or is itself asking. When two neighbours ask at the same moment, the router with the lower mesh ID wins. The ID of a router is `ROW*MESH_COLS+COL`, so the north and west neighbours always win against this router, and this router always wins against its east and south neighbours. Routers in the last column stay Active so that the mesh remains connected.

Top module: `pg_handshake_ctrl`

## Requirements
- R1: During and right after synchronous reset, `state_o` is Active (00), `pg_en_o`, `bypass_o` and `wake_req_o` are low, and every outgoing message is none (00).
- R2: The advertised state is encoded as Active=00, Draining=01, Sleep=10, Wakeup=11. `pg_en_o` is high only in Sleep. `bypass_o` is high in Sleep and Wakeup. `wake_req_o` is high only in Wakeup.
- R3: While `core_asleep_i` is low, a router in Active stays Active no matter what the idle flag shows.
- R4: When the core is asleep and the router may gate, the router sends a gate-request (01) on every existing port from the next cycle onward. Ports are ordered by field: bits [1:0] north, [3:2] east, [5:4] south, [7:6] west. Acks (10) may arrive on different cycles and are accumulated. The router advertises Draining on the cycle after the last missing ack arrives. Ports with no neighbour count as acked, and their inputs are ignored.
- R5: A nack (11) on any existing port while the router is requesting sends it back to Active and stops the request on the next cycle.
- R6: A router does not request while the stored state of any existing neighbour is not Active, or while any existing neighbour is sending a request. The stored state follows the neighbour's advertised state with a delay of one cycle.
- R7: An incoming request is answered on the next cycle on the same port. The answer is ack (10) if this router is Active, and nack (11) if it is in Draining, Sleep or Wakeup.
- R8: When requests cross while this router is requesting, a request from the east or south port is not answered, and this router keeps requesting. A request from the north or west port makes this router drop to Active and ack that port on the next cycle.
- R9: Draining moves to Sleep only on a cycle where `router_idle_i` is high.
- R10: If the core wakes while the router is Draining, the router returns directly to Active on the next cycle.
- R11: Sleep moves to Wakeup on the cycle after the core wakes. Wakeup lasts at least `WAKE_CYCLES` (10) cycles, and returns to Active only once that count is reached and `router_idle_i` is high.
- R12: A router in the last column (`COL == MESH_COLS-1`) never leaves Active, but it still answers requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_asleep_i | input | 1 | Attached processor core is power-gated |
| router_idle_i | input | 1 | Router buffers are empty and nothing is in flight |
| nbr_msg_i | input | 8 | Handshake message from each neighbour, 2 bits per port (N, E, S, W) |
| nbr_state_i | input | 8 | Advertised power state of each neighbour, 2 bits per port |
| nbr_msg_o | output | 8 | Handshake message to each neighbour, 2 bits per port |
| state_o | output | 2 | This router's advertised power state |
| pg_en_o | output | 1 | Power-gate enable for the router core |
| bypass_o | output | 1 | Select the bypass path around the gated core |
| wake_req_o | output | 1 | Router core is in its wakeup phase |

## Verification
Three placements are driven: an interior router with four neighbours, a top-left corner router with only east and south neighbours, and a last-column router. The power-down handshake is tried with acks spread over several cycles, with a nack, with crossing requests from a winning and a losing neighbour, and with a neighbour already draining. Together these show whether the router accumulates acks, aborts on refusal, applies the ID priority in the right direction, and honours the adjacency rule. Drain and wakeup are run with the idle flag held low and held high, which separates the length of the timed wakeup from the wait for idle. Nacks sent into the corner router's missing ports show whether those ports are really ignored.

// File: rtl/pgh_pkg.sv
package pgh_pkg;

    localparam int NUM_PORTS = 4;
    localparam int PORT_N = 0;
    localparam int PORT_E = 1;
    localparam int PORT_S = 2;
    localparam int PORT_W = 3;

    typedef enum logic [1:0] {
        HS_NONE = 2'b00,
        HS_REQ  = 2'b01,
        HS_ACK  = 2'b10,
        HS_NACK = 2'b11
    } hs_msg_e;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_DRAIN  = 2'b01,
        PS_SLEEP  = 2'b10,
        PS_WAKE   = 2'b11
    } pwr_state_e;

    typedef enum logic [2:0] {
        C_ACTIVE = 3'd0,
        C_REQ    = 3'd1,
        C_DRAIN  = 3'd2,
        C_SLEEP  = 3'd3,
        C_WAKE   = 3'd4
    } ctl_state_e;

    function automatic logic [NUM_PORTS-1:0] present_mask(int row, int col, int rows, int cols);
        logic [NUM_PORTS-1:0] m;
        m[PORT_N] = (row > 0);
        m[PORT_E] = (col < cols - 1);
        m[PORT_S] = (row < rows - 1);
        m[PORT_W] = (col > 0);
        return m;
    endfunction

    // This router's ID is lower than its east and south neighbours' IDs
    function automatic bit port_wins(int p);
        return (p == PORT_E) || (p == PORT_S);
    endfunction

    function automatic pwr_state_e advertise(ctl_state_e s);
        case (s)
            C_DRAIN: return PS_DRAIN;
            C_SLEEP: return PS_SLEEP;
            C_WAKE:  return PS_WAKE;
            default: return PS_ACTIVE;
        endcase
    endfunction

endpackage

// File: rtl/pg_wake_timer.sv
module pg_wake_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/pg_nbr_port.sv
module pg_nbr_port
    import pgh_pkg::*;
#(
    parameter bit PRESENT = 1'b1,
    parameter bit WIN     = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  hs_msg_e    msg_in,
    input  logic [1:0] state_in,
    input  ctl_state_e cur,
    output logic       busy_o,
    output logic       req_seen_o,
    output logic       yield_o,
    output logic       nack_o,
    output logic       ack_ok_o,
    output hs_msg_e    resp_o
);
    pwr_state_e psr_q;
    logic       ack_q;
    hs_msg_e    resp_d;
    logic       req_in;

    assign req_in = PRESENT && (msg_in == HS_REQ);

    always_comb begin
        resp_d = HS_NONE;
        if (req_in) begin
            case (cur)
                C_ACTIVE: resp_d = HS_ACK;
                C_REQ:    resp_d = WIN ? HS_NONE : HS_ACK;
                default:  resp_d = HS_NACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psr_q  <= PS_ACTIVE;
            ack_q  <= 1'b0;
            resp_o <= HS_NONE;
        end else begin
            psr_q  <= PRESENT ? pwr_state_e'(state_in) : PS_ACTIVE;
            ack_q  <= PRESENT && (cur == C_REQ) && (ack_q || (msg_in == HS_ACK));
            resp_o <= resp_d;
        end
    end

    assign busy_o     = (psr_q != PS_ACTIVE);
    assign req_seen_o = req_in;
    assign yield_o    = req_in && !WIN && (cur == C_REQ);
    assign nack_o     = PRESENT && (cur == C_REQ) && (msg_in == HS_NACK);
    assign ack_ok_o   = !PRESENT || ack_q || (msg_in == HS_ACK);
endmodule

// File: rtl/pg_handshake_ctrl.sv
module pg_handshake_ctrl
    import pgh_pkg::*;
#(
    parameter int MESH_COLS   = 4,
    parameter int MESH_ROWS   = 4,
    parameter int ROW         = 1,
    parameter int COL         = 1,
    parameter int WAKE_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       core_asleep_i,
    input  logic       router_idle_i,
    input  logic [7:0] nbr_msg_i,
    input  logic [7:0] nbr_state_i,
    output logic [7:0] nbr_msg_o,
    output logic [1:0] state_o,
    output logic       pg_en_o,
    output logic       bypass_o,
    output logic       wake_req_o
);
    localparam logic [NUM_PORTS-1:0] PRESENT = present_mask(ROW, COL, MESH_ROWS, MESH_COLS);
    localparam bit RIGHTMOST = (COL == MESH_COLS - 1);

    ctl_state_e cur, nxt;
    logic [NUM_PORTS-1:0] busy, req_seen, yield_v, nack_v, ack_ok;
    hs_msg_e resp [NUM_PORTS];
    logic wake_done, eligible;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pg_nbr_port #(
            .PRESENT(PRESENT[p]),
            .WIN    (port_wins(p))
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .msg_in    (hs_msg_e'(nbr_msg_i[2*p +: 2])),
            .state_in  (nbr_state_i[2*p +: 2]),
            .cur       (cur),
            .busy_o    (busy[p]),
            .req_seen_o(req_seen[p]),
            .yield_o   (yield_v[p]),
            .nack_o    (nack_v[p]),
            .ack_ok_o  (ack_ok[p]),
            .resp_o    (resp[p])
        );
        assign nbr_msg_o[2*p +: 2] = (cur == C_REQ && PRESENT[p]) ? HS_REQ : resp[p];
    end

    pg_wake_timer #(.CYCLES(WAKE_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (cur == C_WAKE),
        .done(wake_done)
    );

    assign eligible = core_asleep_i && !RIGHTMOST && !(|busy) && !(|req_seen);

    always_comb begin
        nxt = cur;
        case (cur)
            C_ACTIVE: if (eligible) nxt = C_REQ;
            C_REQ: begin
                if (!core_asleep_i || (|yield_v) || (|nack_v) || (|busy)) nxt = C_ACTIVE;
                else if (&ack_ok) nxt = C_DRAIN;
            end
            C_DRAIN: begin
                if (!core_asleep_i) nxt = C_ACTIVE;
                else if (router_idle_i) nxt = C_SLEEP;
            end
            C_SLEEP: if (!core_asleep_i) nxt = C_WAKE;
            C_WAKE:  if (wake_done && router_idle_i) nxt = C_ACTIVE;
            default: nxt = C_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= C_ACTIVE;
        else     cur <= nxt;
    end

    assign state_o    = advertise(cur);
    assign pg_en_o    = (cur == C_SLEEP);
    assign bypass_o   = (cur == C_SLEEP) || (cur == C_WAKE);
    assign wake_req_o = (cur == C_WAKE);
endmodule

// File: rtl/pgh_checker.sv
module pgh_checker
    import pgh_pkg::*;
#(
    parameter int MESH_COLS = 4,
    parameter int MESH_ROWS = 4,
    parameter int ROW       = 1,
    parameter int COL       = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       core_asleep_i,
    input logic       router_idle_i,
    input logic [7:0] nbr_msg_i,
    input logic [7:0] nbr_msg_o,
    input logic [1:0] state_o,
    input logic       pg_en_o,
    input logic       bypass_o,
    input logic       wake_req_o
);
    localparam logic [NUM_PORTS-1:0] PRESENT = present_mask(ROW, COL, MESH_ROWS, MESH_COLS);
    localparam bit RIGHTMOST = (COL == MESH_COLS - 1);

    logic any_req_out, any_req_in;
    always_comb begin
        any_req_out = 1'b0;
        any_req_in  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (nbr_msg_o[2*p +: 2] == HS_REQ) any_req_out = 1'b1;
            if (PRESENT[p] && nbr_msg_i[2*p +: 2] == HS_REQ) any_req_in = 1'b1;
        end
    end

    a_r1_down_order: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP && $past(state_o) != PS_SLEEP) |-> $past(state_o) == PS_DRAIN);

    a_r11_up_order: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_WAKE && $past(state_o) != PS_WAKE) |-> $past(state_o) == PS_SLEEP);

    a_r2_sleep_gated: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP && $past(state_o) == PS_DRAIN) |-> (pg_en_o && bypass_o && !wake_req_o));

    a_r3_core_awake: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_ACTIVE && !core_asleep_i) |=> state_o == PS_ACTIVE);

    a_r9_drain_waits_idle: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_DRAIN && !router_idle_i) |=> state_o != PS_SLEEP);

    a_r11_sleep_exit: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_SLEEP && !core_asleep_i) |=> state_o == PS_WAKE);

    a_r12_last_column: assert property (@(posedge clk) disable iff (rst)
        RIGHTMOST |-> (state_o == PS_ACTIVE && !any_req_out));

    a_r6_hold_off: assert property (@(posedge clk) disable iff (rst)
        (state_o == PS_ACTIVE && !any_req_out && any_req_in) |=> !any_req_out);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        if (PRESENT[p]) begin : g_on
            a_r7_busy_nack: assert property (@(posedge clk) disable iff (rst)
                (nbr_msg_i[2*p +: 2] == HS_REQ && state_o != PS_ACTIVE)
                |=> nbr_msg_o[2*p +: 2] == HS_NACK);
        end
    end
endmodule

bind pg_handshake_ctrl pgh_checker #(
    .MESH_COLS(MESH_COLS),
    .MESH_ROWS(MESH_ROWS),
    .ROW      (ROW),
    .COL      (COL)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .core_asleep_i(core_asleep_i),
    .router_idle_i(router_idle_i),
    .nbr_msg_i    (nbr_msg_i),
    .nbr_msg_o    (nbr_msg_o),
    .state_o      (state_o),
    .pg_en_o      (pg_en_o),
    .bypass_o     (bypass_o),
    .wake_req_o   (wake_req_o)
);

// File: tb/test_pg_handshake_ctrl.sv
`timescale 1ns/1ps
module test_pg_handshake_ctrl;
    localparam int NC = 4, NR = 4, WK = 10;
    localparam int ND = 3;
    localparam int RW [ND] = '{1, 0, 2};
    localparam int CL [ND] = '{1, 0, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       core [ND];
    logic       idle [ND];
    logic [7:0] nmsg [ND];
    logic [7:0] nst  [ND];
    logic [7:0] omsg [ND];
    logic [1:0] ost  [ND];
    logic       pg   [ND];
    logic       byp  [ND];
    logic       wk   [ND];

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    pg_handshake_ctrl #(.MESH_COLS(NC), .MESH_ROWS(NR), .ROW(1), .COL(1), .WAKE_CYCLES(WK)) i_pg_handshake_ctrl (
        .clk(clk), .rst(rst), .core_asleep_i(core[0]), .router_idle_i(idle[0]),
        .nbr_msg_i(nmsg[0]), .nbr_state_i(nst[0]), .nbr_msg_o(omsg[0]), .state_o(ost[0]),
        .pg_en_o(pg[0]), .bypass_o(byp[0]), .wake_req_o(wk[0]));

    pg_handshake_ctrl #(.MESH_COLS(NC), .MESH_ROWS(NR), .ROW(0), .COL(0), .WAKE_CYCLES(WK)) i_pg_handshake_ctrl_corner (
        .clk(clk), .rst(rst), .core_asleep_i(core[1]), .router_idle_i(idle[1]),
        .nbr_msg_i(nmsg[1]), .nbr_state_i(nst[1]), .nbr_msg_o(omsg[1]), .state_o(ost[1]),
        .pg_en_o(pg[1]), .bypass_o(byp[1]), .wake_req_o(wk[1]));

    pg_handshake_ctrl #(.MESH_COLS(NC), .MESH_ROWS(NR), .ROW(2), .COL(3), .WAKE_CYCLES(WK)) i_pg_handshake_ctrl_last (
        .clk(clk), .rst(rst), .core_asleep_i(core[2]), .router_idle_i(idle[2]),
        .nbr_msg_i(nmsg[2]), .nbr_state_i(nst[2]), .nbr_msg_o(omsg[2]), .state_o(ost[2]),
        .pg_en_o(pg[2]), .bypass_o(byp[2]), .wake_req_o(wk[2]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit pres(int d, int p);
        case (p)
            0: return RW[d] > 0;
            1: return CL[d] < NC - 1;
            2: return RW[d] < NR - 1;
            default: return CL[d] > 0;
        endcase
    endfunction

    // Reference model: 0 active, 1 requesting, 2 draining, 3 sleep, 4 wakeup
    int  ms   [ND];
    int  mcnt [ND];
    bit  mack [ND][4];
    int  mresp[ND][4];
    int  mpsr [ND][4];

    always @(posedge clk) begin
        for (int d = 0; d < ND; d++) begin
            if (rst) begin
                ms[d] = 0; mcnt[d] = 0;
                for (int p = 0; p < 4; p++) begin mack[d][p] = 0; mresp[d][p] = 0; mpsr[d][p] = 0; end
            end else begin
                int ns, m, nr [4], npsr [4];
                bit busy, anyrq, yld, nk, allack, rq, win, nack [4];
                busy = 0; anyrq = 0; yld = 0; nk = 0; allack = 1;
                for (int p = 0; p < 4; p++) begin
                    m = int'(nmsg[d][2*p +: 2]);
                    win = (p == 1) || (p == 2);
                    rq = pres(d, p) && m == 1;
                    if (pres(d, p) && mpsr[d][p] != 0) busy = 1;
                    if (rq) anyrq = 1;
                    if (rq && !win && ms[d] == 1) yld = 1;
                    if (pres(d, p) && ms[d] == 1 && m == 3) nk = 1;
                    if (pres(d, p) && !(mack[d][p] || m == 2)) allack = 0;
                    nr[p] = !rq ? 0 : (ms[d] == 0) ? 2 : (ms[d] == 1) ? (win ? 0 : 2) : 3;
                    npsr[p] = pres(d, p) ? int'(nst[d][2*p +: 2]) : 0;
                    nack[p] = pres(d, p) && ms[d] == 1 && (mack[d][p] || m == 2);
                end
                ns = ms[d];
                case (ms[d])
                    0: if (core[d] && CL[d] != NC - 1 && !busy && !anyrq) ns = 1;
                    1: if (!core[d] || yld || nk || busy) ns = 0; else if (allack) ns = 2;
                    2: if (!core[d]) ns = 0; else if (idle[d]) ns = 3;
                    3: if (!core[d]) ns = 4;
                    default: if (mcnt[d] >= WK - 1 && idle[d]) ns = 0;
                endcase
                mcnt[d] = (ms[d] == 4) ? ((mcnt[d] < WK - 1) ? mcnt[d] + 1 : mcnt[d]) : 0;
                for (int p = 0; p < 4; p++) begin
                    mresp[d][p] = nr[p]; mpsr[d][p] = npsr[p]; mack[d][p] = nack[p];
                end
                ms[d] = ns;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            for (int d = 0; d < ND; d++) begin
                int es, em;
                es = (ms[d] <= 1) ? 0 : ms[d] - 1;
                em = 0;
                for (int p = 0; p < 4; p++)
                    em |= ((ms[d] == 1 && pres(d, p)) ? 1 : mresp[d][p]) << (2 * p);
                chk(int'(ost[d]) == es, "R4 model state", int'(ost[d]), es);
                chk(int'(omsg[d]) == em, "R7 model messages", int'(omsg[d]), em);
                chk(pg[d] == (es == 2) && byp[d] == (es >= 2) && wk[d] == (es == 3),
                    "R2 model flags", {pg[d], byp[d], wk[d]}, {es == 2, es >= 2, es == 3});
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Interior router: request, collect all acks, reach Draining
    task automatic gate_down0();
        core[0] = 1; step(1);
        nmsg[0] = 8'hAA; step(1);
        nmsg[0] = 8'h00;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog R4 actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int d = 0; d < ND; d++) begin core[d] = 0; idle[d] = 1; nmsg[d] = 0; nst[d] = 0; end
        step(3);
        // R1: reset values
        chk(ost[0] == 2'b00 && omsg[0] == 8'h00 && !pg[0] && !byp[0] && !wk[0], "R1 reset", ost[0], 0);
        rst = 0;
        step(1);
        chk(ost[0] == 2'b00 && omsg[0] == 8'h00, "R1 after reset", omsg[0], 0);

        // R3: core awake keeps Active regardless of idle
        idle[0] = 0; step(2); idle[0] = 1; step(3);
        chk(ost[0] == 2'b00 && omsg[0] == 8'h00, "R3 core awake", ost[0], 0);

        // R4: request on all ports, acks spread over cycles
        core[0] = 1; step(1);
        chk(omsg[0] == 8'h55 && ost[0] == 2'b00, "R4 request sent", omsg[0], 8'h55);
        nmsg[0] = 8'h2A; step(1);
        nmsg[0] = 8'h00; step(2);
        chk(omsg[0] == 8'h55 && ost[0] == 2'b00, "R4 waits for west ack", omsg[0], 8'h55);
        nmsg[0] = 8'h80; step(1);
        nmsg[0] = 8'h00;
        chk(ost[0] == 2'b01, "R4 draining after last ack", ost[0], 1);

        // R9: Draining holds until idle
        idle[0] = 0; step(4);
        chk(ost[0] == 2'b01 && !pg[0], "R9 drain waits idle", ost[0], 1);
        idle[0] = 1; step(1);
        chk(ost[0] == 2'b10 && pg[0] && byp[0] && !wk[0], "R2 sleep flags", {pg[0], byp[0], wk[0]}, 3'b110);

        // R7: request while asleep is refused
        nmsg[0] = 8'h04; step(1);
        nmsg[0] = 8'h00;
        chk(omsg[0][3:2] == 2'b11, "R7 nack while asleep", omsg[0], 8'h0C);

        // R11: wakeup with idle low stays in Wakeup past the count
        core[0] = 0; idle[0] = 0; step(1);
        chk(ost[0] == 2'b11 && wk[0] && byp[0] && !pg[0], "R11 wake entered", ost[0], 3);
        step(14);
        chk(ost[0] == 2'b11, "R11 waits idle", ost[0], 3);
        idle[0] = 1; step(1);
        chk(ost[0] == 2'b00 && !byp[0], "R11 active after idle", ost[0], 0);

        // R11: exact wakeup length with idle high
        gate_down0(); step(1);
        chk(ost[0] == 2'b10, "R9 sleep again", ost[0], 2);
        core[0] = 0; cnt = 0;
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (ost[0] == 2'b11) cnt++;
        end
        chk(cnt == WK, "R11 wake length", cnt, WK);

        // R5: nack aborts
        core[0] = 1; step(1);
        nmsg[0] = 8'h03; step(1);
        core[0] = 0; nmsg[0] = 8'h00;
        chk(omsg[0] == 8'h00 && ost[0] == 2'b00, "R5 nack aborts", omsg[0], 0);
        step(2);

        // R10: core wakes during Draining
        idle[0] = 0; gate_down0();
        chk(ost[0] == 2'b01, "R10 draining", ost[0], 1);
        core[0] = 0; step(1);
        chk(ost[0] == 2'b00, "R10 abort to active", ost[0], 0);
        idle[0] = 1; step(2);

        // R6: neighbour draining blocks request
        nst[0] = 8'h01; step(1);
        core[0] = 1; step(3);
        chk(omsg[0] == 8'h00 && ost[0] == 2'b00, "R6 neighbour gated", omsg[0], 0);
        core[0] = 0; nst[0] = 8'h00; step(2);
        // R6 + R7: incoming request blocks own request and is acked
        core[0] = 1; nmsg[0] = 8'h10; step(1);
        core[0] = 0; nmsg[0] = 8'h00;
        chk(omsg[0] == 8'h20, "R6 incoming request acked, no own request", omsg[0], 8'h20);
        step(2);

        // R8: crossing requests
        core[0] = 1; step(1);
        nmsg[0] = 8'h04; step(1);
        chk(omsg[0] == 8'h55, "R8 east request ignored", omsg[0], 8'h55);
        nmsg[0] = 8'h01; step(1);
        core[0] = 0; nmsg[0] = 8'h00;
        chk(omsg[0] == 8'h02 && ost[0] == 2'b00, "R8 yield to north", omsg[0], 8'h02);
        step(2);

        // R7: ack while active
        nmsg[0] = 8'h40; step(1);
        nmsg[0] = 8'h00;
        chk(omsg[0] == 8'h80, "R7 ack while active", omsg[0], 8'h80);

        // R4: corner router, missing ports auto-ack and are ignored
        core[1] = 1; nmsg[1] = 8'hC3; step(1);
        chk(omsg[1] == 8'h14, "R4 corner requests E,S only", omsg[1], 8'h14);
        nmsg[1] = 8'hEB; step(1);
        nmsg[1] = 8'h00;
        chk(ost[1] == 2'b01, "R4 corner drains", ost[1], 1);
        core[1] = 0; step(2);

        // R12: last column never gates, still answers
        core[2] = 1; step(20);
        chk(ost[2] == 2'b00 && omsg[2] == 8'h00 && !pg[2], "R12 stays active", ost[2], 0);
        nmsg[2] = 8'h01; step(1);
        nmsg[2] = 8'h00;
        chk(omsg[2] == 8'h02, "R12 acks request", omsg[2], 8'h02);
        step(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule